// File: doc/BRIEF.md
# Per-Context Local Interrupt Unit

This block keeps the private interrupt state of several processor contexts. Each context has five local sources: a timer, a performance counter, a debug channel and two software interrupts. The unit samples the level of each source into a pending register. A mask register selects which pending bits count, and a map register per source says whether that source may drive the context's interrupt line and which pin number it carries. The mask is changed only through set and clear strobe registers.

A simple register bus reaches the unit through two windows. The local window always addresses the context that issues the access. The remote window addresses whichever context the requester last named in its own remote-select register. Each context has a control register. It holds a writable external-controller mode bit and read-only capability flags. These decide whether a source's map register may be written. The unit drives one interrupt line per context.

Top module: `lir_top`

## Requirements
- R1: The pending register of every context is loaded each clock with the level of its source inputs (source s of context c is `src_i[c*5+s]`, sources ordered timer, perf, debug, sw0, sw1), so a level change shows in pending one clock later; pending reads at offset 1.
- R2: Writing a value to the set-strobe register (offset 3) sets the mask bits written as one and leaves the others unchanged. The mask reads at offset 2, and the set-strobe register reads as zero.
- R3: Writing a value to the clear-strobe register (offset 4) clears the mask bits written as one and leaves the others unchanged; writing all ones leaves every mask bit clear.
- R4: `irq_o[c]` is high exactly when some source of context c has its pending bit, its mask bit and its map enable all set.
- R5: Address bit 5 picks the window. With bit 5 clear, an access targets the requesting context `bus_ctx_i`. With bit 5 set, it targets the context whose index that requester last wrote to its remote-select register (offset 5, local window only, 3 bits wide).
- R6: The control register (offset 0) holds the mode bit in bit 0, which is readable and writable. Bits 1 to 4 read the timer, perf, debug and shared software-interrupt capability flags, which are fixed by parameter; writes to bits 1 to 4 have no effect.
- R7: Map register s (offset 8+s) has its enable in bit 31 and its pin number in bits 2:0. A write to it takes effect only when the mode bit of the target context is set or the capability flag of that source is set; otherwise the register keeps its value.
- R8: When the remote window names a context index of N or more, reads return zero and writes change no state.
- R9: After reset every mask, map register, mode bit and remote-select register is zero and every interrupt line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | NUM_CTX*5 | Level inputs of the local sources, five per context |
| bus_req_i | input | 1 | Register access valid this cycle |
| bus_we_i | input | 1 | Access is a write |
| bus_ctx_i | input | CTX_W | Index of the requesting context |
| bus_addr_i | input | 6 | Bit 5 window select, bits 4:0 register offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, same cycle as the request |
| irq_o | output | NUM_CTX | Interrupt line per context |

## Verification
Directed patterns first walk one context through its masking steps: set, partial clear and full clear. They show whether zero bits in a strobe are truly left alone and whether the strobe registers read back as zero. Map writes are tried with the mode bit clear and then set, on a source whose capability flag is off. This separates the capability gating from the mode override. Remote-window accesses are made with a valid index and with an out-of-range one, and the results are read back through the local window of other contexts. This shows whether the window routed to the right register file or touched none. Seeded random sequences then mix writes through both windows, reads and source changes. Every interrupt line and a random register are compared each step, which exposes cross-context leakage.

// File: rtl/lir_pkg.sv
package lir_pkg;
  localparam int NUM_SRC  = 5;
  localparam int NUM_CAPS = 4;

  localparam int SRC_TIMER = 0;
  localparam int SRC_PERF  = 1;
  localparam int SRC_DEBUG = 2;
  localparam int SRC_SW0   = 3;
  localparam int SRC_SW1   = 4;

  localparam int OFF_CTRL  = 0;
  localparam int OFF_PEND  = 1;
  localparam int OFF_MASK  = 2;
  localparam int OFF_SSET  = 3;
  localparam int OFF_SCLR  = 4;
  localparam int OFF_RSEL  = 5;
  localparam int OFF_MAP0  = 8;

  // both software sources share one capability flag
  function automatic int cap_group(input int src);
    return (src >= SRC_SW0) ? 3 : src;
  endfunction
endpackage

// File: rtl/lir_decode.sv
module lir_decode #(
  parameter int NUM_CTX = 4,
  parameter int CTX_W   = 2,
  parameter int SEL_W   = 3,
  parameter int ADDR_W  = 6
) (
  input  logic [CTX_W-1:0]  req_ctx_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SEL_W-1:0]  req_rsel_i,
  output logic [SEL_W-1:0]  tgt_o,
  output logic              tgt_ok_o,
  output logic              remote_o,
  output logic [ADDR_W-2:0] off_o
);
  always_comb begin
    remote_o = addr_i[ADDR_W-1];
    off_o    = addr_i[ADDR_W-2:0];
    tgt_o    = remote_o ? req_rsel_i : SEL_W'(req_ctx_i);
    tgt_ok_o = (int'(tgt_o) < NUM_CTX);
  end
endmodule

// File: rtl/lir_ctx.sv
module lir_ctx
  import lir_pkg::*;
#(
  parameter int                PIN_W  = 3,
  parameter int                DATA_W = 32,
  parameter int                OFF_W  = 5,
  parameter logic [NUM_CAPS-1:0] CAPS = 4'b0101
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       src_i,
  input  logic                     wr_i,
  input  logic [OFF_W-1:0]         off_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic                     mode_o,
  output logic [NUM_SRC-1:0]       pend_o,
  output logic [NUM_SRC-1:0]       mask_o,
  output logic [NUM_SRC-1:0]       men_o,
  output logic [NUM_SRC*PIN_W-1:0] mpin_o,
  output logic                     irq_o
);
  logic                     mode_q, mode_d;
  logic [NUM_SRC-1:0]       pend_q;
  logic [NUM_SRC-1:0]       mask_q, mask_d;
  logic [NUM_SRC-1:0]       men_q, men_d;
  logic [NUM_SRC*PIN_W-1:0] mpin_q, mpin_d;
  logic [NUM_SRC-1:0]       routable;
  logic                     cfg_en;

  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) begin
      routable[s] = mode_q | CAPS[cap_group(s)];
    end
  end

  assign cfg_en = wr_i;

  always_comb begin
    mode_d = mode_q;
    mask_d = mask_q;
    men_d  = men_q;
    mpin_d = mpin_q;
    if (wr_i) begin
      if (off_i == OFF_W'(OFF_CTRL)) mode_d = wdata_i[0];
      if (off_i == OFF_W'(OFF_SSET)) mask_d = mask_q | wdata_i[NUM_SRC-1:0];
      if (off_i == OFF_W'(OFF_SCLR)) mask_d = mask_q & ~wdata_i[NUM_SRC-1:0];
      for (int s = 0; s < NUM_SRC; s++) begin
        if (off_i == OFF_W'(OFF_MAP0 + s) && routable[s]) begin
          men_d[s]                  = wdata_i[DATA_W-1];
          mpin_d[s*PIN_W +: PIN_W]  = wdata_i[PIN_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= src_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      mask_q <= '0;
      men_q  <= '0;
      mpin_q <= '0;
    end else if (cfg_en) begin
      mode_q <= mode_d;
      mask_q <= mask_d;
      men_q  <= men_d;
      mpin_q <= mpin_d;
    end
  end

  assign mode_o = mode_q;
  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign men_o  = men_q;
  assign mpin_o = mpin_q;
  assign irq_o  = |(pend_q & mask_q & men_q);

  p_pend_track_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pend_q == $past(src_i));

  p_set_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && off_i == OFF_W'(OFF_SSET)) |=>
      ((mask_q & $past(wdata_i[NUM_SRC-1:0])) == $past(wdata_i[NUM_SRC-1:0])));

  p_clr_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && off_i == OFF_W'(OFF_SCLR)) |=>
      ((mask_q & $past(wdata_i[NUM_SRC-1:0])) == '0));

  p_irq_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> |(pend_q & mask_q));

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_lock
    p_map_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && off_i == OFF_W'(OFF_MAP0 + g) && !mode_q && !CAPS[cap_group(g)])
        |=> ($stable(men_q[g]) && $stable(mpin_q[g*PIN_W +: PIN_W])));
  end
endmodule

// File: rtl/lir_top.sv
module lir_top
  import lir_pkg::*;
#(
  parameter int                  NUM_CTX    = 4,
  parameter int                  PIN_W      = 3,
  parameter int                  DATA_W     = 32,
  parameter int                  ADDR_W     = 6,
  parameter logic [NUM_CAPS-1:0] ROUTE_CAPS = 4'b0101,
  localparam int                 CTX_W      = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  localparam int                 SEL_W      = CTX_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_CTX*NUM_SRC-1:0] src_i,
  input  logic                       bus_req_i,
  input  logic                       bus_we_i,
  input  logic [CTX_W-1:0]           bus_ctx_i,
  input  logic [ADDR_W-1:0]          bus_addr_i,
  input  logic [DATA_W-1:0]          bus_wdata_i,
  output logic [DATA_W-1:0]          bus_rdata_o,
  output logic [NUM_CTX-1:0]         irq_o
);
  localparam int OFF_W = ADDR_W - 1;

  logic rst_m_q, rst_s_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  logic [SEL_W-1:0]         rsel_q [NUM_CTX];
  logic [SEL_W-1:0]         req_rsel;
  logic [SEL_W-1:0]         tgt;
  logic                     tgt_ok, remote;
  logic [OFF_W-1:0]         off;
  logic                     wr_any;
  logic                     req_ctx_ok;

  logic                     mode_a [NUM_CTX];
  logic [NUM_SRC-1:0]       pend_a [NUM_CTX];
  logic [NUM_SRC-1:0]       mask_a [NUM_CTX];
  logic [NUM_SRC-1:0]       men_a  [NUM_CTX];
  logic [NUM_SRC*PIN_W-1:0] mpin_a [NUM_CTX];

  assign req_ctx_ok = (int'(bus_ctx_i) < NUM_CTX);
  assign req_rsel   = req_ctx_ok ? rsel_q[bus_ctx_i] : '0;
  assign wr_any     = bus_req_i & bus_we_i;

  lir_decode #(
    .NUM_CTX(NUM_CTX), .CTX_W(CTX_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W)
  ) u_decode (
    .req_ctx_i (bus_ctx_i),
    .addr_i    (bus_addr_i),
    .req_rsel_i(req_rsel),
    .tgt_o     (tgt),
    .tgt_ok_o  (tgt_ok),
    .remote_o  (remote),
    .off_o     (off)
  );

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    logic ctx_wr;
    logic rsel_wr;
    logic [SEL_W-1:0] rsel_d;

    assign ctx_wr  = wr_any & tgt_ok & (tgt == SEL_W'(c));
    assign rsel_wr = wr_any & ~remote & (off == OFF_W'(OFF_RSEL))
                     & (bus_ctx_i == CTX_W'(c));
    assign rsel_d  = bus_wdata_i[SEL_W-1:0];

    always_ff @(posedge clk or negedge rst_s_q) begin
      if (!rst_s_q)     rsel_q[c] <= '0;
      else if (rsel_wr) rsel_q[c] <= rsel_d;
    end

    lir_ctx #(
      .PIN_W(PIN_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .CAPS(ROUTE_CAPS)
    ) u_ctx (
      .clk    (clk),
      .rst_n  (rst_s_q),
      .src_i  (src_i[c*NUM_SRC +: NUM_SRC]),
      .wr_i   (ctx_wr),
      .off_i  (off),
      .wdata_i(bus_wdata_i),
      .mode_o (mode_a[c]),
      .pend_o (pend_a[c]),
      .mask_o (mask_a[c]),
      .men_o  (men_a[c]),
      .mpin_o (mpin_a[c]),
      .irq_o  (irq_o[c])
    );
  end

  always_comb begin
    logic [CTX_W-1:0] t;
    bus_rdata_o = '0;
    t = tgt[CTX_W-1:0];
    if (bus_req_i && !bus_we_i && tgt_ok) begin
      if (off == OFF_W'(OFF_CTRL)) begin
        bus_rdata_o[0]          = mode_a[t];
        bus_rdata_o[NUM_CAPS:1] = ROUTE_CAPS;
      end
      if (off == OFF_W'(OFF_PEND)) bus_rdata_o[NUM_SRC-1:0] = pend_a[t];
      if (off == OFF_W'(OFF_MASK)) bus_rdata_o[NUM_SRC-1:0] = mask_a[t];
      if (off == OFF_W'(OFF_RSEL) && !remote) bus_rdata_o[SEL_W-1:0] = req_rsel;
      for (int s = 0; s < NUM_SRC; s++) begin
        if (off == OFF_W'(OFF_MAP0 + s)) begin
          bus_rdata_o[DATA_W-1]  = men_a[t][s];
          bus_rdata_o[PIN_W-1:0] = mpin_a[t][s*PIN_W +: PIN_W];
        end
      end
    end
  end

  p_oob_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_s_q)
    (bus_req_i && !bus_we_i && !tgt_ok) |-> bus_rdata_o == '0);

  p_local_target_r5: assert property (@(posedge clk) disable iff (!rst_s_q)
    (bus_req_i && !bus_addr_i[ADDR_W-1]) |-> (tgt == SEL_W'(bus_ctx_i)));

  p_reset_quiet_r9: assert property (@(posedge clk)
    !rst_s_q |-> irq_o == '0);
endmodule

// File: tb/test_lir_top.sv
`timescale 1ns/1ps
module test_lir_top;
  localparam int NC = 4;
  localparam int NS = 5;
  localparam logic [3:0] CAPS = 4'b0101;

  logic          clk, rst_n;
  logic [NC*NS-1:0] src;
  logic          req, we;
  logic [1:0]    ctx;
  logic [5:0]    addr;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic [NC-1:0] irq;

  int n_tests, n_fail;

  logic [4:0] m_pend [NC];
  logic [4:0] m_mask [NC];
  logic [4:0] m_en   [NC];
  logic [2:0] m_pin  [NC][NS];
  logic       m_ext  [NC];
  logic [2:0] m_sel  [NC];

  lir_top i_lir_top (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_req_i(req), .bus_we_i(we),
    .bus_ctx_i(ctx), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int grp(input int s);
    return (s >= 3) ? 3 : s;
  endfunction

  function automatic int tgt_of(input int c, input logic [5:0] a);
    return a[5] ? int'(m_sel[c]) : c;
  endfunction

  function automatic logic [31:0] exp_read(input int c, input logic [5:0] a);
    int t, o;
    logic [31:0] r;
    r = '0;
    t = tgt_of(c, a);
    o = int'(a[4:0]);
    if (t < NC) begin
      if (o == 0) r = {27'd0, CAPS, m_ext[t]};
      if (o == 1) r[4:0] = m_pend[t];
      if (o == 2) r[4:0] = m_mask[t];
      if (o == 5 && !a[5]) r[2:0] = m_sel[c];
      if (o >= 8 && o < 8 + NS) begin
        r[31]  = m_en[t][o-8];
        r[2:0] = m_pin[t][o-8];
      end
    end
    return r;
  endfunction

  function automatic logic [NC-1:0] exp_irq();
    logic [NC-1:0] v;
    for (int c = 0; c < NC; c++) v[c] = |(m_pend[c] & m_mask[c] & m_en[c]);
    return v;
  endfunction

  task automatic model_write(input int c, input logic [5:0] a, input logic [31:0] d);
    int t, o;
    t = tgt_of(c, a);
    o = int'(a[4:0]);
    if (o == 5 && !a[5]) m_sel[c] = d[2:0];
    if (t < NC) begin
      if (o == 0) m_ext[t] = d[0];
      if (o == 3) m_mask[t] = m_mask[t] | d[4:0];
      if (o == 4) m_mask[t] = m_mask[t] & ~d[4:0];
      if (o >= 8 && o < 8 + NS && (m_ext[t] || CAPS[grp(o-8)])) begin
        m_en[t][o-8]  = d[31];
        m_pin[t][o-8] = d[2:0];
      end
    end
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input int c, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; ctx = 2'(c); addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    model_write(c, a, d);
  endtask

  task automatic bus_rd(input string tag, input int c, input logic [5:0] a);
    @(negedge clk);
    req = 1'b1; we = 1'b0; ctx = 2'(c); addr = a;
    #1;
    check(tag, rdata, exp_read(c, a));
    req = 1'b0;
  endtask

  task automatic set_src(input logic [NC*NS-1:0] v);
    @(negedge clk);
    src = v;
    @(negedge clk);
    for (int c = 0; c < NC; c++) m_pend[c] = v[c*NS +: NS];
  endtask

  task automatic check_irq(input string tag);
    #1;
    check(tag, 32'(irq), 32'(exp_irq()));
  endtask

  initial begin
    #(8 * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got hang expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [5:0] offs [9];
    n_tests = 0; n_fail = 0;
    offs = '{6'd0, 6'd1, 6'd2, 6'd3, 6'd4, 6'd5, 6'd8, 6'd9, 6'd12};
    void'($urandom(32'd1234));
    rst_n = 1'b0; req = 1'b0; we = 1'b0; ctx = '0; addr = '0; wdata = '0; src = '0;
    for (int c = 0; c < NC; c++) begin
      m_pend[c] = '0; m_mask[c] = '0; m_en[c] = '0; m_ext[c] = 1'b0; m_sel[c] = '0;
      for (int s = 0; s < NS; s++) m_pin[c][s] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    check_irq("R9 irq low");
    bus_rd("R9 mask zero", 0, 6'd2);
    bus_rd("R9 map zero", 1, 6'd8);
    bus_rd("R9 R6 ctrl caps", 2, 6'd0);
    bus_rd("R9 rsel zero", 3, 6'd5);

    // R1 pending follows sources
    set_src('1);
    bus_rd("R1 pend all", 0, 6'd1);
    check_irq("R4 masked off");

    // R2 set strobe
    bus_wr(0, 6'd3, 32'h05);
    bus_rd("R2 mask set", 0, 6'd2);
    bus_wr(0, 6'd3, 32'h02);
    bus_rd("R2 zeros kept", 0, 6'd2);
    bus_rd("R2 strobe reads zero", 0, 6'd3);

    // R4 map timer (routable)
    bus_wr(0, 6'd8, 32'h8000_0002);
    bus_rd("R7 timer map", 0, 6'd8);
    check_irq("R4 irq on");

    // R3 clear strobe
    bus_wr(0, 6'd4, 32'h01);
    bus_rd("R3 mask clr", 0, 6'd2);
    check_irq("R4 irq off");

    // R7 perf not routable, then mode bit override
    bus_wr(0, 6'd9, 32'h8000_0003);
    bus_rd("R7 locked map", 0, 6'd9);
    check_irq("R7 locked irq");
    bus_wr(0, 6'd0, 32'h1);
    bus_wr(0, 6'd9, 32'h8000_0003);
    bus_rd("R7 mode override", 0, 6'd9);
    check_irq("R7 R4 irq via perf");

    // R6 caps read only
    bus_wr(0, 6'd0, 32'hFFFF_FFFF);
    bus_rd("R6 caps kept", 0, 6'd0);

    // R5 remote window
    bus_wr(0, 6'd5, 32'd2);
    bus_wr(0, 6'h23, 32'h1F);
    bus_rd("R5 remote write lands", 2, 6'd2);
    bus_rd("R5 remote read", 0, 6'h22);
    bus_rd("R5 other ctx untouched", 1, 6'd2);

    // R8 out-of-range remote index
    bus_wr(1, 6'd5, 32'd5);
    bus_rd("R8 oob read zero", 1, 6'h20);
    bus_wr(1, 6'h23, 32'h1F);
    bus_wr(1, 6'h20, 32'h1);
    for (int c = 0; c < NC; c++) begin
      bus_rd("R8 no mask change", c, 6'd2);
      bus_rd("R8 no ctrl change", c, 6'd0);
    end

    // R3 all ones clears all
    bus_wr(2, 6'd4, 32'hFFFF_FFFF);
    bus_rd("R3 all cleared", 2, 6'd2);
    check_irq("R4 after clear");

    // random phase
    for (int i = 0; i < 600; i++) begin
      int c, k;
      logic [5:0] a;
      c = int'($urandom_range(NC-1));
      k = int'($urandom_range(8));
      a = offs[k];
      if ($urandom_range(3) == 0) a[5] = 1'b1;
      case ($urandom_range(4))
        0: set_src(NC*NS'($urandom));
        1, 2: begin
          logic [31:0] d;
          d = $urandom;
          if (a[4:0] == 5'd5) d = 32'($urandom_range(5));
          bus_wr(c, a, d);
        end
        default: bus_rd("R5 R8 random read", c, a);
      endcase
      check_irq("R4 random irq");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule